// File: doc/BRIEF.md
# Load/Store Effective Address and Base Update Unit

This block works out where a single-word or single-byte memory access goes and what the base register becomes afterwards. It takes an instruction word together with the values of its base and index registers, the carry flag and the address of the current instruction. It returns the access address, a flag that says whether the base register is rewritten, and the value to write.

The offset is either a 12-bit unsigned constant taken from the instruction or the index register passed through a constant-amount shifter. The offset is added or subtracted. The access uses either the base register before the update (post-indexed) or after it (pre-indexed). Results leave the block through one register stage, marked by a valid strobe. Fetching the data, alignment and the register file stay outside the block.

Top module: `lsag_top`

## Requirements
- R1: When bit 24 of the instruction is 0 (post-indexed), the access address equals the base value.
- R2: When bit 24 is 1 (pre-indexed), the access address is base plus offset if bit 23 is 1, and base minus offset if bit 23 is 0.
- R3: When bit 24 is 0, the base is always rewritten, whatever bit 21 holds. The write value is base plus offset when bit 23 is 1 and base minus offset when bit 23 is 0.
- R4: When bit 24 is 1, the base is rewritten only if bit 21 is 1, and the write value then equals the access address.
- R5: When bit 25 is 0, the offset is bits [11:0] zero-extended to the data width.
- R6: When bit 25 is 1, the offset is the index value shifted by the amount in bits [11:7]. Bits [6:5] pick the shift: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right.
- R7: A right logical shift with amount 0 gives an offset of 0.
- R8: A right arithmetic shift with amount 0 fills every bit of the offset with the index value's top bit.
- R9: A rotate with amount 0 gives the carry flag in the top bit and the index value's upper bits shifted down by one below it.
- R10: When bits [19:16] equal 15, the base value is the current instruction address plus 8, and the base input is not used.
- R11: Results appear one clock after the input strobe, with out_valid high for exactly that cycle. After reset, out_valid and wb_en are 0.
- R12: Bits 22, 20, 4 and [3:0] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Load/store instruction word |
| rn_val | input | 32 | Base register value |
| rm_val | input | 32 | Index register value |
| carry_in | input | 1 | Current carry flag |
| pc_in | input | 32 | Address of the current instruction |
| out_valid | output | 1 | Results below are valid |
| acc_addr | output | 32 | Effective access address |
| wb_en | output | 1 | Base register is to be rewritten |
| wb_data | output | 32 | New base register value |

## Verification
The assertions assume that the instruction and operand inputs are stable and known in any cycle where in_valid is high. They also assume that in_valid is low while reset is held, because the timing properties relate out_valid to the strobe one cycle earlier. The bench drives inputs only at the falling edge, holds in_valid low throughout reset, and mixes directed words for every index mode, shift kind and zero-amount case with random words in which the base field is sometimes 15.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
   localparam int INSTR_W    = 32;
   localparam int BIT_REGOFF = 25;
   localparam int BIT_PRE    = 24;
   localparam int BIT_UP     = 23;
   localparam int BIT_WBREQ  = 21;
   localparam int BASE_LSB   = 16;
   localparam int BASE_IDX_W = 4;
   localparam int AMT_LSB    = 7;
   localparam int KIND_LSB   = 5;
   localparam int IMM_W      = 12;

   typedef enum logic [1:0] {
      SHK_LSL = 2'b00,
      SHK_LSR = 2'b01,
      SHK_ASR = 2'b10,
      SHK_ROR = 2'b11
   } shift_kind_e;

   typedef struct packed {
      logic                  reg_off;
      logic                  pre;
      logic                  up;
      logic                  wb_req;
      logic [BASE_IDX_W-1:0] base_idx;
      logic [4:0]            amt;
      shift_kind_e           kind;
      logic [IMM_W-1:0]      imm;
   } ls_fields_t;

   function automatic ls_fields_t ls_decode(input logic [INSTR_W-1:0] w);
      ls_fields_t f;
      f.reg_off  = w[BIT_REGOFF];
      f.pre      = w[BIT_PRE];
      f.up       = w[BIT_UP];
      f.wb_req   = w[BIT_WBREQ];
      f.base_idx = w[BASE_LSB +: BASE_IDX_W];
      f.amt      = w[AMT_LSB +: 5];
      f.kind     = shift_kind_e'(w[KIND_LSB +: 2]);
      f.imm      = w[IMM_W-1:0];
      return f;
   endfunction
endpackage

// File: rtl/lsag_shifter.sv
module lsag_shifter
   import lsag_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int SHAMT_W   = 5,
   parameter bit LOG_STAGE = 1'b1
) (
   input  logic [DATA_W-1:0]  rm,
   input  logic [SHAMT_W-1:0] amt,
   input  shift_kind_e        kind,
   input  logic               carry,
   output logic [DATA_W-1:0]  result
);
   localparam int DBL_W = 2 * DATA_W;

   logic              amt_zero;
   logic [DATA_W-1:0] shifted;

   assign amt_zero = (amt == '0);

   if (LOG_STAGE) begin : g_log
      logic [DATA_W-1:0] rm_rev, src, out_rev;
      logic              fill, rot, left;

      assign left = (kind == SHK_LSL);
      assign rot  = (kind == SHK_ROR);
      assign fill = (kind == SHK_ASR) ? rm[DATA_W-1] : 1'b0;

      for (genvar b = 0; b < DATA_W; b++) begin : g_rev_in
         assign rm_rev[b] = rm[DATA_W-1-b];
      end
      assign src = left ? rm_rev : rm;

      for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
         localparam int S = 1 << k;
         logic [DATA_W-1:0] prev, res;
         logic [S-1:0]      hi;
         if (k == 0) begin : g_first
            assign prev = src;
         end else begin : g_next
            assign prev = g_stage[k-1].res;
         end
         assign hi  = rot ? prev[S-1:0] : {S{fill}};
         assign res = amt[k] ? {hi, prev[DATA_W-1:S]} : prev;
      end

      for (genvar b = 0; b < DATA_W; b++) begin : g_rev_out
         assign out_rev[b] = g_stage[SHAMT_W-1].res[DATA_W-1-b];
      end
      assign shifted = left ? out_rev : g_stage[SHAMT_W-1].res;
   end else begin : g_op
      logic [DBL_W-1:0] dbl;
      assign dbl = {rm, rm} >> amt;
      always_comb begin
         unique case (kind)
            SHK_LSL: shifted = rm << amt;
            SHK_LSR: shifted = rm >> amt;
            SHK_ASR: shifted = $unsigned($signed(rm) >>> amt);
            default: shifted = dbl[DATA_W-1:0];
         endcase
      end
   end

   always_comb begin
      result = shifted;
      if (amt_zero) begin
         unique case (kind)
            SHK_LSR: result = '0;
            SHK_ASR: result = {DATA_W{rm[DATA_W-1]}};
            SHK_ROR: result = {carry, rm[DATA_W-1:1]};
            default: result = rm;
         endcase
      end
   end
endmodule

// File: rtl/lsag_offset_sel.sv
module lsag_offset_sel
   import lsag_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              reg_off,
   input  logic [IMM_W-1:0]  imm,
   input  logic [DATA_W-1:0] shifted,
   output logic [DATA_W-1:0] offset
);
   localparam int PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;
   assign imm_ext = {{PAD_W{1'b0}}, imm};
   assign offset  = reg_off ? shifted : imm_ext;
endmodule

// File: rtl/lsag_index_unit.sv
module lsag_index_unit #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] base,
   input  logic [DATA_W-1:0] offset,
   input  logic              pre,
   input  logic              up,
   input  logic              wb_req,
   output logic [DATA_W-1:0] addr,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_data
);
   logic [DATA_W-1:0] moved;

   assign moved   = up ? (base + offset) : (base - offset);
   assign addr    = pre ? moved : base;
   assign wb_en   = ~pre | wb_req;
   assign wb_data = moved;
endmodule

// File: rtl/lsag_top.sv
module lsag_top
   import lsag_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SHAMT_W     = 5,
   parameter int PC_OFFSET   = 8,
   parameter int PC_BASE_IDX = 15,
   parameter bit LOG_STAGE   = 1'b1,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       instr,
   input  logic [DATA_W-1:0] rn_val,
   input  logic [DATA_W-1:0] rm_val,
   input  logic              carry_in,
   input  logic [DATA_W-1:0] pc_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] acc_addr,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_data
);
   localparam logic [DATA_W-1:0]     PC_ADJ  = DATA_W'(PC_OFFSET);
   localparam logic [BASE_IDX_W-1:0] PC_CODE = BASE_IDX_W'(PC_BASE_IDX);

   if ((1 << SHAMT_W) > DATA_W) begin : g_bad_shamt
      $error("lsag_top: SHAMT_W too wide for DATA_W");
   end
   if (DATA_W <= IMM_W) begin : g_bad_width
      $error("lsag_top: DATA_W must exceed the immediate width");
   end
   if (SHAMT_W != 5) begin : g_bad_field
      $error("lsag_top: shift amount field is five bits");
   end

   ls_fields_t        fld;
   logic [DATA_W-1:0] base_eff;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] c_offset;
   logic [DATA_W-1:0] c_addr;
   logic              c_wb_en;
   logic [DATA_W-1:0] c_wb_data;

   assign fld      = ls_decode(instr);
   assign base_eff = (fld.base_idx == PC_CODE) ? (pc_in + PC_ADJ) : rn_val;

   lsag_shifter #(
      .DATA_W    (DATA_W),
      .SHAMT_W   (SHAMT_W),
      .LOG_STAGE (LOG_STAGE)
   ) shifter_i (
      .rm     (rm_val),
      .amt    (fld.amt),
      .kind   (fld.kind),
      .carry  (carry_in),
      .result (shifted)
   );

   lsag_offset_sel #(
      .DATA_W (DATA_W)
   ) offsel_i (
      .reg_off (fld.reg_off),
      .imm     (fld.imm),
      .shifted (shifted),
      .offset  (c_offset)
   );

   lsag_index_unit #(
      .DATA_W (DATA_W)
   ) index_i (
      .base    (base_eff),
      .offset  (c_offset),
      .pre     (fld.pre),
      .up      (fld.up),
      .wb_req  (fld.wb_req),
      .addr    (c_addr),
      .wb_en   (c_wb_en),
      .wb_data (c_wb_data)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
            acc_addr  <= '0;
            wb_data   <= '0;
         end else begin
            out_valid <= in_valid;
            wb_en     <= in_valid & c_wb_en;
            if (in_valid) begin
               acc_addr <= c_addr;
               wb_data  <= c_wb_data;
            end
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign wb_en     = in_valid & c_wb_en;
      assign acc_addr  = c_addr;
      assign wb_data   = c_wb_data;
   end
endmodule

// File: rtl/lsag_checker.sv
module lsag_checker #(
   parameter int DATA_W    = 32,
   parameter int PC_OFFSET = 8,
   parameter bit REG_OUT   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [31:0]       instr,
   input logic [DATA_W-1:0] base_eff,
   input logic [DATA_W-1:0] c_offset,
   input logic [DATA_W-1:0] c_addr,
   input logic              c_wb_en,
   input logic [DATA_W-1:0] c_wb_data,
   input logic              out_valid,
   input logic [DATA_W-1:0] acc_addr,
   input logic              wb_en,
   input logic [DATA_W-1:0] wb_data
);
   logic [DATA_W-1:0] sum_v, dif_v, moved_v;
   assign sum_v   = base_eff + c_offset;
   assign dif_v   = base_eff - c_offset;
   assign moved_v = instr[23] ? sum_v : dif_v;

   assert_post_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !instr[24]) |-> (c_addr == base_eff));

   assert_pre_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[24]) |-> (c_addr == moved_v));

   assert_post_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !instr[24]) |-> (c_wb_en && c_wb_data == moved_v));

   assert_pre_nowb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[24] && !instr[21]) |-> !c_wb_en);

   assert_pre_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[24] && instr[21]) |-> (c_wb_en && c_wb_data == c_addr));

   assert_imm_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !instr[25]) |-> (c_offset == DATA_W'(instr[11:0])));

   if (REG_OUT) begin : g_seq
      assert_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> $past(in_valid));
      assert_addr_pipe_R11: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (acc_addr == $past(c_addr)));
      assert_wb_pipe_R11: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (wb_en == $past(c_wb_en) && (!wb_en || wb_data == $past(c_wb_data))));
      assert_wb_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid |-> !wb_en);
   end
endmodule

bind lsag_top lsag_checker #(
   .DATA_W    (DATA_W),
   .PC_OFFSET (PC_OFFSET),
   .REG_OUT   (REG_OUT)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .instr     (instr),
   .base_eff  (base_eff),
   .c_offset  (c_offset),
   .c_addr    (c_addr),
   .c_wb_en   (c_wb_en),
   .c_wb_data (c_wb_data),
   .out_valid (out_valid),
   .acc_addr  (acc_addr),
   .wb_en     (wb_en),
   .wb_data   (wb_data)
);

// File: tb/lsag_top_tb_top.sv
module lsag_top_tb_top;
   typedef struct {
      string       tag;
      logic [31:0] addr;
      logic        wbe;
      logic [31:0] wbd;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rn_val = '0;
   logic [31:0] rm_val = '0;
   logic        carry_in = 1'b0;
   logic [31:0] pc_in = '0;
   logic        out_valid;
   logic [31:0] acc_addr;
   logic        wb_en;
   logic [31:0] wb_data;

   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #10 clk = ~clk;

   lsag_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .instr     (instr),
      .rn_val    (rn_val),
      .rm_val    (rm_val),
      .carry_in  (carry_in),
      .pc_in     (pc_in),
      .out_valid (out_valid),
      .acc_addr  (acc_addr),
      .wb_en     (wb_en),
      .wb_data   (wb_data)
   );

   function automatic exp_t model(string tag, logic [31:0] w, logic [31:0] rn,
                                  logic [31:0] rm, logic c, logic [31:0] pc);
      exp_t        e;
      logic [31:0] base, off, moved;
      int          amt;
      amt  = int'(w[11:7]);
      base = (w[19:16] == 4'd15) ? pc + 32'd8 : rn;
      case (w[6:5])
         2'b00: off = rm << amt;
         2'b01: off = (amt == 0) ? 32'd0 : rm >> amt;
         2'b10: off = (amt == 0) ? {32{rm[31]}} : $unsigned($signed(rm) >>> amt);
         default: off = (amt == 0) ? {c, rm[31:1]} : ((rm >> amt) | (rm << (32 - amt)));
      endcase
      if (!w[25]) off = {20'd0, w[11:0]};
      moved  = w[23] ? base + off : base - off;
      e.tag  = tag;
      e.addr = w[24] ? moved : base;
      e.wbe  = !w[24] || w[21];
      e.wbd  = moved;
      return e;
   endfunction

   function automatic logic [31:0] mk_imm(bit p, bit u, bit wb, logic [3:0] rn, logic [11:0] imm);
      return {4'hE, 2'b01, 1'b0, p, u, 1'b0, wb, 1'b1, rn, 4'h2, imm};
   endfunction

   function automatic logic [31:0] mk_reg(bit p, bit u, bit wb, logic [3:0] rn,
                                          logic [4:0] amt, logic [1:0] kind);
      return {4'hE, 2'b01, 1'b1, p, u, 1'b0, wb, 1'b1, rn, 4'h2, amt, kind, 1'b0, 4'h3};
   endfunction

   task automatic drive(string tag, logic [31:0] w, logic [31:0] rn, logic [31:0] rm,
                        logic c, logic [31:0] pc);
      @(negedge clk);
      instr    = w;
      rn_val   = rn;
      rm_val   = rm;
      carry_in = c;
      pc_in    = pc;
      in_valid = 1'b1;
      q.push_back(model(tag, w, rn, rm, c, pc));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         instr    = $urandom;
      end
   endtask

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
      end
   endtask

   // monitor: R11 one-cycle latency and output comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (q.size() == 0) begin
               check("R11", "unexpected out_valid", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(e.tag, "acc_addr", acc_addr, e.addr);
               check(e.tag, "wb_en", {31'd0, wb_en}, {31'd0, e.wbe});
               if (e.wbe) check(e.tag, "wb_data", wb_data, e.wbd);
            end
         end else if (q.size() != 0 && !in_valid) begin
            check("R11", "missing out_valid", 32'd0, 32'd1);
            void'(q.pop_front());
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      check("R11", "out_valid after reset", {31'd0, out_valid}, 32'd0);
      check("R11", "wb_en after reset", {31'd0, wb_en}, 32'd0);

      // R1 / R3 post-indexed, W both ways, add and subtract
      drive("R1", mk_imm(0, 1, 0, 4'd3, 12'h104), 32'h0000_1000, 32'h0, 0, 32'h0);
      drive("R3", mk_imm(0, 0, 1, 4'd3, 12'hFFF), 32'h0000_1000, 32'h0, 0, 32'h0);
      drive("R3", mk_imm(0, 0, 0, 4'd3, 12'h001), 32'h0000_0000, 32'h0, 0, 32'h0);
      // R2 / R4 pre-indexed with and without update
      drive("R2", mk_imm(1, 1, 0, 4'd4, 12'h010), 32'h8000_0000, 32'h0, 0, 32'h0);
      drive("R4", mk_imm(1, 0, 1, 4'd4, 12'h020), 32'h0000_0100, 32'h0, 0, 32'h0);
      drive("R4", mk_imm(1, 0, 0, 4'd4, 12'h020), 32'h0000_0100, 32'h0, 0, 32'h0);
      // R5 maximum immediate
      drive("R5", mk_imm(1, 1, 0, 4'd1, 12'hFFF), 32'hFFFF_F000, 32'hFFFF_FFFF, 0, 32'h0);
      // R6 each shift kind, nonzero amounts
      drive("R6", mk_reg(1, 1, 0, 4'd2, 5'd2, 2'b00), 32'h100, 32'h8000_0003, 0, 32'h0);
      drive("R6", mk_reg(1, 1, 0, 4'd2, 5'd31, 2'b01), 32'h100, 32'h8000_0000, 0, 32'h0);
      drive("R6", mk_reg(1, 1, 0, 4'd2, 5'd4, 2'b10), 32'h100, 32'h8000_00F0, 0, 32'h0);
      drive("R6", mk_reg(1, 0, 1, 4'd2, 5'd8, 2'b11), 32'h100, 32'h1234_5678, 1, 32'h0);
      drive("R6", mk_reg(0, 1, 0, 4'd2, 5'd0, 2'b00), 32'h100, 32'hDEAD_BEEF, 1, 32'h0);
      // R7 / R8 / R9 zero-amount specials
      drive("R7", mk_reg(1, 1, 0, 4'd5, 5'd0, 2'b01), 32'h200, 32'hFFFF_FFFF, 1, 32'h0);
      drive("R8", mk_reg(1, 1, 0, 4'd5, 5'd0, 2'b10), 32'h200, 32'h8000_0000, 0, 32'h0);
      drive("R8", mk_reg(1, 1, 0, 4'd5, 5'd0, 2'b10), 32'h200, 32'h7FFF_FFFF, 1, 32'h0);
      drive("R9", mk_reg(1, 1, 0, 4'd5, 5'd0, 2'b11), 32'h200, 32'h0000_0003, 1, 32'h0);
      drive("R9", mk_reg(1, 1, 0, 4'd5, 5'd0, 2'b11), 32'h200, 32'h8000_0002, 0, 32'h0);
      // R10 base field 15 uses pc + 8
      drive("R10", mk_imm(1, 1, 0, 4'd15, 12'h004), 32'hAAAA_AAAA, 32'h0, 0, 32'h0000_8000);
      drive("R10", mk_imm(0, 0, 0, 4'd15, 12'h00C), 32'h5555_5555, 32'h0, 0, 32'h0000_0010);
      idle(3);
      // R11 back-to-back after a gap
      drive("R11", mk_imm(1, 1, 1, 4'd6, 12'h001), 32'h1, 32'h0, 0, 32'h0);
      idle(1);
      // R12 bits 22, 20, 4, [3:0] toggled: same expectation as the clean word
      drive("R12", mk_reg(1, 1, 1, 4'd7, 5'd3, 2'b00) | 32'h0050_001F, 32'h40, 32'h11, 0, 32'h0);
      drive("R12", mk_imm(0, 0, 1, 4'd7, 12'h0F0) | 32'h0050_0000, 32'h400, 32'h0, 1, 32'h0);
      // random mix across all requirements
      for (int i = 0; i < 300; i++) begin
         drive("R6", $urandom, $urandom, $urandom, 1'($urandom), $urandom);
         if ((i % 17) == 0) idle(1);
      end
      idle(4);
      if (q.size() != 0) check("R11", "results outstanding", q.size(), 32'd0);
      finish_run();
   end
endmodule